// File: doc/BRIEF.md
# H-Bridge Gate Command and Fault Controller

This block is the digital core of a full-bridge motor driver. It takes two direction inputs, a speed-modulation (PWM) input and two per-leg enable levels, and produces on/off commands for the four power switches: the high-side and low-side switch of leg A and of leg B. The direction pair selects one of four bridge states: brake to supply, forward, reverse, or brake to ground. The PWM input chops only the low-side switches.

Each leg shares one diagnostic line with the outside world. That line is modelled as a sampled enable level plus a pull-down output. When a leg sees over-temperature on its high side or saturation on its low side, it latches itself off and drives its pull-down. It stays off until its direction input rises again with the fault flag gone. An undervoltage or overvoltage flag turns the whole bridge off at once.

Any change in the requested switch pattern blanks all four switches for a programmable number of clock cycles before the new pattern is applied. This prevents cross-conduction. A test mode drives only the high side selected by each direction input, and reports a disconnected load on the matching diagnostic line. Direction, PWM and enable inputs pass through a two-flop synchroniser before use. The fault, supply, test and open-load flags are treated as already synchronous.

Top module: `hb_bridge_ctrl`

## Requirements
- R1: With both legs enabled, no faults, supply good, PWM high and test mode off, the settled outputs follow the direction pair. Written as (dir_a, dir_b) giving {hs_a, ls_a, hs_b, ls_b}: 11 gives 1010, 10 gives 1001, 01 gives 0110, 00 gives 0101.
- R2: A leg never has its high-side and low-side commands asserted in the same cycle.
- R3: PWM masks only the low-side commands, and the high sides are unaffected. A PWM change driven before clock edge E0 is still invisible after E0 and takes effect after edge E1.
- R4: While a leg's synchronised enable level is low, both of its switches are off in steady state. The other leg settles to its truth-table state.
- R5: An over-temperature or saturation flag seen at a clock edge latches that leg off. From the next cycle the leg's pull-down is asserted and both of its switches are off, even though its enable input stays high.
- R6: A latched leg stays off with its pull-down asserted after the flag drops. It is released only by a low-to-high transition of its synchronised direction input at a time when its fault flag is low. A rise that happens while the flag is high does not release it.
- R7: While uv_i or ov_i is high, all four switch commands are low in the same cycle, with no clock edge needed.
- R8: When the requested pattern changes, all four commands are low during a guard of GUARD_CYC cycles. For a direction change driven before edge E0, outputs are still off after edge E(GUARD_CYC+1) and show the new pattern after edge E(GUARD_CYC+2). No high side turns on except at the end of a guard.
- R9: In test mode (test_i high) both low sides are off, and each high side follows its direction input. Each pull-down equals that leg's open-load flag, OR-ed with its latched fault.
- R10: During reset all six outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a_i | input | 1 | Direction input, leg A |
| dir_b_i | input | 1 | Direction input, leg B |
| pwm_i | input | 1 | Low-side modulation input |
| en_a_i | input | 1 | Sampled level of leg A diagnostic/enable line |
| en_b_i | input | 1 | Sampled level of leg B diagnostic/enable line |
| ot_a_i | input | 1 | Over-temperature flag, high side A |
| ot_b_i | input | 1 | Over-temperature flag, high side B |
| sat_a_i | input | 1 | Saturation flag, low side A |
| sat_b_i | input | 1 | Saturation flag, low side B |
| uv_i | input | 1 | Supply undervoltage flag |
| ov_i | input | 1 | Supply overvoltage flag |
| test_i | input | 1 | Load-continuity test mode request |
| open_a_i | input | 1 | Load-disconnect flag, output A (test mode) |
| open_b_i | input | 1 | Load-disconnect flag, output B (test mode) |
| hs_a_o | output | 1 | High-side A on command |
| ls_a_o | output | 1 | Low-side A on command |
| hs_b_o | output | 1 | High-side B on command |
| ls_b_o | output | 1 | Low-side B on command |
| diag_pd_a_o | output | 1 | Pull-down drive for leg A diagnostic line |
| diag_pd_b_o | output | 1 | Pull-down drive for leg B diagnostic line |

## Verification
The bench builds the block with GUARD_CYC set to 8 and the default two synchroniser stages. The default guard of 60000 cycles would leave only a handful of pattern changes inside the run budget. The short guard lets the bench measure the exact edge at which a new pattern appears, and still leaves room for several hundred random pattern changes. It also allows full latch-and-release sequences on both legs, including a release attempt while a saturation flag is still high.

// File: rtl/hb_pkg.sv
package hb_pkg;

  localparam int LEGS = 2;

  // Leg may conduct only with its line released, no latched fault and a good supply.
  function automatic logic leg_enabled(input logic en_s, input logic flt, input logic supply_ok);
    return en_s & ~flt & supply_ok;
  endfunction

  // Requested {hs, ls} of one leg before PWM and guard.
  function automatic logic [1:0] leg_request(input logic dir_s, input logic ok, input logic test);
    logic hs;
    logic ls;
    hs = ok & dir_s;
    ls = ok & ~dir_s & ~test;
    return {hs, ls};
  endfunction

  // PWM chops only the low side.
  function automatic logic [1:0] pwm_gate(input logic [1:0] cmd, input logic pwm_s);
    return {cmd[1], cmd[0] & pwm_s};
  endfunction

  // Pull-down drive of the shared diagnostic line.
  function automatic logic diag_pull(input logic flt, input logic test, input logic open_flag);
    return flt | (test & open_flag);
  endfunction

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/hb_fault_latch.sv
module hb_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic dir_s_i,
  output logic restart_o,
  output logic flt_o
);

  logic dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= 1'b0;
    else        dir_q <= dir_s_i;
  end

  // Restart event: rising edge of the synchronised direction input.
  assign restart_o = dir_s_i & ~dir_q;

  // A live fault wins over a simultaneous restart.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flt_o <= 1'b0;
    else if (fault_i)   flt_o <= 1'b1;
    else if (restart_o) flt_o <= 1'b0;
  end

endmodule

// File: rtl/hb_mode_guard.sv
module hb_mode_guard #(
  parameter int W         = 4,
  parameter int GUARD_CYC = 60000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] cur_o,
  output logic         busy_o
);

  localparam int CW = $clog2(GUARD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(GUARD_CYC);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_o <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
      if (cnt_q == ONE) cur_o <= req_i;
    end else if (req_i != cur_o) begin
      cnt_q <= LOAD;
    end
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/hb_bridge_ctrl.sv
module hb_bridge_ctrl
  import hb_pkg::*;
#(
  parameter int GUARD_CYC   = 60000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_a_i,
  input  logic dir_b_i,
  input  logic pwm_i,
  input  logic en_a_i,
  input  logic en_b_i,
  input  logic ot_a_i,
  input  logic ot_b_i,
  input  logic sat_a_i,
  input  logic sat_b_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic test_i,
  input  logic open_a_i,
  input  logic open_b_i,
  output logic hs_a_o,
  output logic ls_a_o,
  output logic hs_b_o,
  output logic ls_b_o,
  output logic diag_pd_a_o,
  output logic diag_pd_b_o
);

  localparam int NCMD = 2 * LEGS;
  localparam int SW   = 2 * LEGS + 1;

  logic [LEGS-1:0] dir_raw, en_raw, ot_raw, sat_raw, open_raw;
  logic [LEGS-1:0] dir_s, en_s;
  logic            pwm_s;
  logic            supply_ok;
  logic [LEGS-1:0] flt_vec, restart_vec, leg_ok, diag_pd;
  logic [NCMD-1:0] req_cmd, cur_cmd, live_cmd, gate_cmd;
  logic            guard_busy;

  assign dir_raw  = {dir_b_i, dir_a_i};
  assign en_raw   = {en_b_i, en_a_i};
  assign ot_raw   = {ot_b_i, ot_a_i};
  assign sat_raw  = {sat_b_i, sat_a_i};
  assign open_raw = {open_b_i, open_a_i};

  hb_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({pwm_i, en_raw, dir_raw}),
    .q_o   ({pwm_s, en_s, dir_s})
  );

  assign supply_ok = ~(uv_i | ov_i);

  // Commands that are applied and still requested; a withdrawn switch drops at once.
  assign live_cmd = cur_cmd & req_cmd;

  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    hb_fault_latch u_flt (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_i   (ot_raw[g] | sat_raw[g]),
      .dir_s_i   (dir_s[g]),
      .restart_o (restart_vec[g]),
      .flt_o     (flt_vec[g])
    );
    assign leg_ok[g]          = leg_enabled(en_s[g], flt_vec[g], supply_ok);
    assign req_cmd[2*g +: 2]  = leg_request(dir_s[g], leg_ok[g], test_i);
    assign gate_cmd[2*g +: 2] = guard_busy ? 2'b00 : pwm_gate(live_cmd[2*g +: 2], pwm_s);
    assign diag_pd[g]         = diag_pull(flt_vec[g], test_i, open_raw[g]);
  end

  hb_mode_guard #(.W(NCMD), .GUARD_CYC(GUARD_CYC)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_cmd),
    .cur_o  (cur_cmd),
    .busy_o (guard_busy)
  );

  assign hs_a_o      = gate_cmd[1];
  assign ls_a_o      = gate_cmd[0];
  assign hs_b_o      = gate_cmd[3];
  assign ls_b_o      = gate_cmd[2];
  assign diag_pd_a_o = diag_pd[0];
  assign diag_pd_b_o = diag_pd[1];

endmodule

// File: rtl/hb_bridge_ctrl_chk.sv
module hb_bridge_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwm_i,
  input logic       ot_a_i,
  input logic       ot_b_i,
  input logic       sat_a_i,
  input logic       sat_b_i,
  input logic       uv_i,
  input logic       ov_i,
  input logic       test_i,
  input logic       hs_a_o,
  input logic       ls_a_o,
  input logic       hs_b_o,
  input logic       ls_b_o,
  input logic       diag_pd_a_o,
  input logic       diag_pd_b_o,
  input logic       guard_busy,
  input logic [1:0] flt_vec,
  input logic [1:0] restart_vec
);

  assert_leg_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a_o && ls_a_o) && !(hs_b_o && ls_b_o));

  assert_pwm_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwm_i, 2) |-> (!ls_a_o && !ls_b_o));

  assert_fault_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_a_i || sat_a_i) |=> (diag_pd_a_o && !hs_a_o && !ls_a_o));

  assert_fault_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_b_i || sat_b_i) |=> (diag_pd_b_o && !hs_b_o && !ls_b_o));

  assert_release_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_vec[0]) |-> ($past(restart_vec[0]) && !$past(ot_a_i || sat_a_i)));

  assert_release_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_vec[1]) |-> ($past(restart_vec[1]) && !$past(ot_b_i || sat_b_i)));

  assert_supply_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_i || ov_i) |-> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));

  assert_guard_hs_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_a_o) |-> $past(guard_busy));

  assert_guard_hs_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_b_o) |-> $past(guard_busy));

  assert_test_ls_R9: assert property (@(posedge clk) disable iff (!rst_n)
    test_i |-> (!ls_a_o && !ls_b_o));

endmodule

bind hb_bridge_ctrl hb_bridge_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwm_i       (pwm_i),
  .ot_a_i      (ot_a_i),
  .ot_b_i      (ot_b_i),
  .sat_a_i     (sat_a_i),
  .sat_b_i     (sat_b_i),
  .uv_i        (uv_i),
  .ov_i        (ov_i),
  .test_i      (test_i),
  .hs_a_o      (hs_a_o),
  .ls_a_o      (ls_a_o),
  .hs_b_o      (hs_b_o),
  .ls_b_o      (ls_b_o),
  .diag_pd_a_o (diag_pd_a_o),
  .diag_pd_b_o (diag_pd_b_o),
  .guard_busy  (guard_busy),
  .flt_vec     (flt_vec),
  .restart_vec (restart_vec)
);

// File: tb/hb_bridge_ctrl_tb.sv
module hb_bridge_ctrl_tb;

  localparam int G      = 8;
  localparam int SETTLE = G + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_a = 0, dir_b = 0, pwm = 0, en_a = 0, en_b = 0;
  logic ot_a = 0, ot_b = 0, sat_a = 0, sat_b = 0, uv = 0, ov = 0, tm = 0, op_a = 0, op_b = 0;
  logic hs_a, ls_a, hs_b, ls_b, pd_a, pd_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hb_bridge_ctrl #(.GUARD_CYC(G), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_a_i(dir_a), .dir_b_i(dir_b), .pwm_i(pwm),
    .en_a_i(en_a), .en_b_i(en_b), .ot_a_i(ot_a), .ot_b_i(ot_b),
    .sat_a_i(sat_a), .sat_b_i(sat_b), .uv_i(uv), .ov_i(ov), .test_i(tm),
    .open_a_i(op_a), .open_b_i(op_b), .hs_a_o(hs_a), .ls_a_o(ls_a),
    .hs_b_o(hs_b), .ls_b_o(ls_b), .diag_pd_a_o(pd_a), .diag_pd_b_o(pd_b)
  );

  function automatic logic [3:0] exp_gates(input logic da, input logic db, input logic ea,
                                           input logic eb, input logic pw, input logic t,
                                           input logic bad, input logic fa, input logic fb);
    logic oka, okb;
    oka = ea && !fa && !bad;
    okb = eb && !fb && !bad;
    return {oka & da, oka & !da & !t & pw, okb & db, okb & !db & !t & pw};
  endfunction

  function automatic logic [1:0] exp_pd(input logic t, input logic oa, input logic ob,
                                        input logic fa, input logic fb);
    return {fa | (t & oa), fb | (t & ob)};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic chk_gates(input string req, input logic [3:0] e);
    logic [3:0] a;
    a = {hs_a, ls_a, hs_b, ls_b};
    chk(a === e, req, {4'h0, a}, {4'h0, e});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    // R10: reset state
    step(3);
    chk_gates("R10 gates in reset", 4'b0000);
    chk({pd_a, pd_b} === 2'b00, "R10 pulldowns in reset", {6'h0, pd_a, pd_b}, 8'h00);
    en_a = 1; en_b = 1; pwm = 1;
    rst_n = 1;
    step(2);

    // R1: truth table
    for (int p = 3; p >= 0; p--) begin
      dir_a = p[1]; dir_b = p[0];
      step(SETTLE);
      chk_gates($sformatf("R1 pattern %0d%0d", p[1], p[0]), exp_gates(p[1], p[0], 1, 1, 1, 0, 0, 0, 0));
    end

    // R8: guard timing, 10 -> 01
    dir_a = 1; dir_b = 0;
    step(SETTLE);
    dir_a = 0; dir_b = 1;
    step(3);
    chk_gates("R8 blank during guard", 4'b0000);
    step(G - 1);
    chk_gates("R8 still blank after E(G+1)", 4'b0000);
    step(1);
    chk_gates("R8 new pattern after E(G+2)", 4'b0110);

    // R3: PWM latency, hs unaffected
    dir_a = 1; dir_b = 0;
    step(SETTLE);
    pwm = 0;
    step(1);
    chk_gates("R3 pwm not yet seen after E0", 4'b1001);
    step(1);
    chk_gates("R3 low side masked after E1, high side kept", 4'b1000);
    pwm = 1;
    step(2);
    chk_gates("R3 low side back", 4'b1001);

    // R4: enable low
    en_a = 0;
    step(SETTLE);
    chk_gates("R4 leg A disabled", 4'b0001);
    en_a = 1;
    step(SETTLE);

    // R7: supply fault, combinational
    uv = 1;
    #1;
    chk_gates("R7 undervoltage off same cycle", 4'b0000);
    uv = 0; ov = 1;
    step(2);
    chk_gates("R7 overvoltage off", 4'b0000);
    ov = 0;
    step(SETTLE);
    chk_gates("R7 restored", 4'b1001);

    // R5: over-temperature latches leg A
    ot_a = 1;
    step(1);
    ot_a = 0;
    chk(pd_a === 1'b1 && !hs_a && !ls_a, "R5 leg A latched next cycle",
        {5'h0, pd_a, hs_a, ls_a}, 8'h04);
    step(SETTLE);
    // R6: held after flag drops
    chk(pd_a === 1'b1, "R6 pulldown held", {7'h0, pd_a}, 8'h01);
    chk_gates("R6 leg A held off with enable high", 4'b0001);
    dir_a = 0;
    step(SETTLE);
    sat_a = 1; dir_a = 1;
    step(SETTLE);
    chk(pd_a === 1'b1, "R6 rise during live fault ignored", {7'h0, pd_a}, 8'h01);
    sat_a = 0;
    step(SETTLE);
    chk_gates("R6 no release without new rise", 4'b0001);
    dir_a = 0;
    step(SETTLE);
    dir_a = 1;
    step(SETTLE);
    chk(pd_a === 1'b0, "R6 released by rise", {7'h0, pd_a}, 8'h00);
    chk_gates("R6 leg A back", 4'b1001);

    // R5: saturation on leg B
    sat_b = 1;
    step(1);
    sat_b = 0;
    chk(pd_b === 1'b1 && !hs_b && !ls_b, "R5 leg B latched by saturation",
        {5'h0, pd_b, hs_b, ls_b}, 8'h04);
    dir_b = 1;
    step(SETTLE);
    chk_gates("R5 leg B released after rise", 4'b1010);

    // R9: test mode
    tm = 1; dir_a = 1; dir_b = 0; op_b = 1;
    step(SETTLE);
    chk_gates("R9 test mode high side A only", 4'b1000);
    chk({pd_a, pd_b} === 2'b01, "R9 open load on B", {6'h0, pd_a, pd_b}, 8'h01);
    tm = 0; op_b = 0;
    step(SETTLE);

    // Random phase: R1, R2, R3, R4, R9
    for (int it = 0; it < 300; it++) begin
      logic da, db, ea, eb, pw, t, oa, ob;
      int excl_bad;
      da = 1'($urandom); db = 1'($urandom);
      ea = ($urandom % 6) != 0; eb = ($urandom % 6) != 0;
      pw = ($urandom % 4) != 0; t = ($urandom % 5) == 0;
      oa = 1'($urandom); ob = 1'($urandom);
      dir_a = da; dir_b = db; en_a = ea; en_b = eb; pwm = pw; tm = t; op_a = oa; op_b = ob;
      excl_bad = 0;
      for (int c = 0; c < SETTLE; c++) begin
        step(1);
        if ((hs_a && ls_a) || (hs_b && ls_b)) excl_bad++;
      end
      chk(excl_bad == 0, "R2 leg exclusion", 8'(excl_bad), 8'h00);
      chk_gates("R1 R3 R4 R9 random settle", exp_gates(da, db, ea, eb, pw, t, 0, 0, 0));
      chk({pd_a, pd_b} === exp_pd(t, oa, ob, 0, 0), "R9 random pulldowns",
          {6'h0, pd_a, pd_b}, {6'h0, exp_pd(t, oa, ob, 0, 0)});
    end

    finish_run();
  end

endmodule